// File: doc/BRIEF.md
# Table-Driven Pixel Depth Converter

This block widens pixel data from a narrow depth (typically 1 or 2 bits per pixel) to a wider depth by table lookup, and packs the wide results into a 32-bit output word. A caller issues one operation per request. A lookup takes a bit field out of a 32-bit source word and uses it to index a loadable table. The looked-up value goes to one of two result registers. A packing operation moves the "lookup" register into a field of the "assembly" register.

Bit offsets count from the most significant bit of a word. Table entries are read as 1, 2 or 4 bytes, and narrower entries are zero-extended. Packing comes in two forms. Place mode drops a field straight into its final position. Accumulate mode shifts the word built so far left and appends the new field. Both forms build the same word when a sequence covers the whole word. The table is loaded through a separate write port. Program sequencing and the pixel memory sit outside the block.

Top module: `pixconv_top`

## Requirements
- R1: While `rst` is high at a rising edge, `rs_o` and `rd_o` become zero and `done_o` and `err_o` are low after that edge.
- R2: A request presented with `req_valid` high at rising edge k takes effect at edge k+1. At that edge `done_o` pulses high for one cycle and the result registers update. Requests may arrive on every cycle and complete in issue order. `done_o` never rises without a request two edges earlier.
- R3: A lookup index is `(req_rt >> (32 - (ofs + n))) & ((1 << n) - 1)`, where bit offset 0 is the most significant bit of `req_rt`.
- R4: `tbl_we` high at an edge writes `tbl_data` at `tbl_addr`. A lookup returns the entry zero-extended from its low 1, 2 or 4 bytes for `req_esize` 0, 1 or 2.
- R5: `req_op` 0 puts the lookup result in `rd_o` and leaves `rs_o` unchanged. `req_op` 1 puts it in `rs_o` and leaves `rd_o` unchanged.
- R6: `req_op` 2 (place) with offset 0 sets `rs_o = rd_o << (32 - n)`. With a nonzero offset it sets `rs_o = rs_o | (rd_o << (32 - (ofs + n)))`. `rd_o` is unchanged.
- R7: `req_op` 3 (accumulate) with offset 0 sets `rs_o = rd_o`. With a nonzero offset it sets `rs_o = (rs_o << n) | rd_o`. `rd_o` is unchanged.
- R8: Four lookup/place pairs covering 8-bit fields at offsets 0, 8, 16, 24 produce the same output word as four lookup/accumulate pairs over the same pixels.
- R9: A request is in error when n is 0 or `ofs + n > 32`. A lookup is also in error when n is above 8 or `req_esize` is 3. An erroneous request raises `err_o` together with its `done_o` and leaves `rs_o` and `rd_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table write address |
| tbl_data | input | 32 | Table write data |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 lookup to D, 1 lookup to S, 2 place, 3 accumulate |
| req_ofs | input | 5 | Field offset from the MSB |
| req_nbits | input | 6 | Field width n |
| req_esize | input | 2 | Entry size: 0 one byte, 1 two bytes, 2 four bytes |
| req_rt | input | 32 | Source word for lookups |
| rs_o | output | 32 | Assembly register |
| rd_o | output | 32 | Lookup register |
| done_o | output | 1 | Request completed this cycle |
| err_o | output | 1 | Completed request was rejected |

## Verification
The hardest case to reach is back-to-back dependence. A place or accumulate request must see the `rd_o` value written by the lookup issued just one cycle earlier, while that lookup's table read is still in flight. The stimulus issues lookup and pack requests on consecutive cycles with no idle gaps. It does this for 2-bit and 1-bit source pixels at several source offsets. A scoreboard compares every completion against a step model. The finished word is also compared against a pixel-level reference, so a stale operand anywhere in the chain shows up as a wrong packed byte.

// File: rtl/pixconv_pkg.sv
package pixconv_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = $clog2(WORD_W);
    localparam int NB_W   = OFS_W + 1;
    localparam int SPAN_W = NB_W + 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_LUT_D = 2'd0,
        OP_LUT_S = 2'd1,
        OP_PLACE = 2'd2,
        OP_ACCUM = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ESZ_B1  = 2'd0,
        ESZ_B2  = 2'd1,
        ESZ_B4  = 2'd2,
        ESZ_BAD = 2'd3
    } esz_e;

    typedef struct packed {
        logic             vld;
        logic             bad;
        op_e              op;
        logic [OFS_W-1:0] ofs;
        logic [NB_W-1:0]  nb;
        esz_e             esz;
    } stage_t;

    function automatic logic [SPAN_W-1:0] span_of(logic [OFS_W-1:0] ofs, logic [NB_W-1:0] nb);
        return SPAN_W'(ofs) + SPAN_W'(nb);
    endfunction

    // distance from the field's lsb to bit 0; valid for span 1..WORD_W
    function automatic logic [NB_W-1:0] low_shift(logic [SPAN_W-1:0] span);
        return NB_W'(SPAN_W'(WORD_W) - span);
    endfunction

    function automatic int unsigned lane_count(esz_e e);
        case (e)
            ESZ_B1:  return 1;
            ESZ_B2:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/pixconv_table.sv
module pixconv_table #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pixconv_extract.sv
module pixconv_extract
    import pixconv_pkg::*;
#(
    parameter int AW    = 8,
    parameter int MAX_N = 8
) (
    input  op_e              op,
    input  logic [OFS_W-1:0] ofs,
    input  logic [NB_W-1:0]  nb,
    input  esz_e             esz,
    input  word_t            rt,
    output logic [AW-1:0]    idx,
    output logic             bad
);
    localparam logic [SPAN_W-1:0] WORD_V = SPAN_W'(WORD_W);
    localparam logic [NB_W-1:0]   MAXN_V = NB_W'(MAX_N);

    logic [SPAN_W-1:0] span;
    logic              span_bad;
    logic              is_lut;
    logic [NB_W-1:0]   sh;
    logic [AW-1:0]     raw;
    logic [AW-1:0]     mask;

    always_comb begin
        span     = span_of(ofs, nb);
        span_bad = (nb == '0) || (span > WORD_V);
        is_lut   = (op == OP_LUT_D) || (op == OP_LUT_S);
        bad      = span_bad || (is_lut && ((nb > MAXN_V) || (esz == ESZ_BAD)));
        sh       = span_bad ? '0 : low_shift(span);
        raw      = AW'(rt >> sh);
        for (int i = 0; i < AW; i++) mask[i] = (NB_W'(i) < nb);
        idx      = raw & mask;
    end
endmodule

// File: rtl/pixconv_zext.sv
module pixconv_zext
    import pixconv_pkg::*;
(
    input  esz_e  esz,
    input  word_t din,
    output word_t dout
);
    localparam int LANES = WORD_W / 8;

    int unsigned keep;
    assign keep = lane_count(esz);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign dout[8*b +: 8] = (b < keep) ? din[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/pixconv_pack.sv
module pixconv_pack
    import pixconv_pkg::*;
(
    input  op_e              op,
    input  logic [OFS_W-1:0] ofs,
    input  logic [NB_W-1:0]  nb,
    input  word_t            rs_cur,
    input  word_t            rd_cur,
    output word_t            rs_nxt
);
    logic first;
    assign first = (ofs == '0);

    always_comb begin
        case (op)
            OP_PLACE: rs_nxt = first
                             ? (rd_cur << low_shift(SPAN_W'(nb)))
                             : (rs_cur | (rd_cur << low_shift(span_of(ofs, nb))));
            OP_ACCUM: rs_nxt = first ? rd_cur : ((rs_cur << nb) | rd_cur);
            default:  rs_nxt = rs_cur;
        endcase
    end
endmodule

// File: rtl/pixconv_top.sv
module pixconv_top
    import pixconv_pkg::*;
#(
    parameter int TBL_AW = 8,
    parameter int MAX_N  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [WORD_W-1:0] tbl_data,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [NB_W-1:0]   req_nbits,
    input  logic [1:0]        req_esize,
    input  logic [WORD_W-1:0] req_rt,
    output logic [WORD_W-1:0] rs_o,
    output logic [WORD_W-1:0] rd_o,
    output logic              done_o,
    output logic              err_o
);
    op_e               op_in;
    esz_e              esz_in;
    logic [TBL_AW-1:0] idx;
    logic              req_bad;
    word_t             tbl_q;
    word_t             lut_val;
    word_t             packed_rs;
    stage_t            s1;

    assign op_in  = op_e'(req_op);
    assign esz_in = esz_e'(req_esize);

    pixconv_extract #(.AW(TBL_AW), .MAX_N(MAX_N)) u_ext (
        .op  (op_in),
        .ofs (req_ofs),
        .nb  (req_nbits),
        .esz (esz_in),
        .rt  (req_rt),
        .idx (idx),
        .bad (req_bad)
    );

    pixconv_table #(.AW(TBL_AW), .DW(WORD_W)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .re    (req_valid),
        .raddr (idx),
        .rdata (tbl_q)
    );

    // stage 1: request fields travel alongside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= req_valid;
            s1.bad <= req_bad;
            s1.op  <= op_in;
            s1.ofs <= req_ofs;
            s1.nb  <= req_nbits;
            s1.esz <= esz_in;
        end
    end

    pixconv_zext u_zext (
        .esz  (s1.esz),
        .din  (tbl_q),
        .dout (lut_val)
    );

    pixconv_pack u_pack (
        .op     (s1.op),
        .ofs    (s1.ofs),
        .nb     (s1.nb),
        .rs_cur (rs_o),
        .rd_cur (rd_o),
        .rs_nxt (packed_rs)
    );

    // stage 2: in-order commit to the result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rs_o   <= '0;
            rd_o   <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= s1.vld;
            err_o  <= s1.vld && s1.bad;
            if (s1.vld && !s1.bad) begin
                case (s1.op)
                    OP_LUT_D: rd_o <= lut_val;
                    OP_LUT_S: rs_o <= lut_val;
                    default:  rs_o <= packed_rs;
                endcase
            end
        end
    end
endmodule

// File: rtl/pixconv_chk.sv
module pixconv_chk
    import pixconv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [1:0]        req_esize,
    input logic              done_o,
    input logic              err_o,
    input logic [WORD_W-1:0] rs_o,
    input logic [WORD_W-1:0] rd_o
);
    AST_DONE_LAT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ##1 done_o); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ##1 !done_o); // R2

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> ($stable(rs_o) && $stable(rd_o))); // R9

    AST_LUT_D_KEEPS_RS: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid, 2) && ($past(req_op, 2) == 2'd0)) |-> $stable(rs_o)); // R5

    AST_PACK_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid, 2) && $past(req_op[1], 2)) |-> $stable(rd_o)); // R6

    AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid, 2) && ($past(req_op, 2) == 2'd0) && ($past(req_esize, 2) == 2'd0)
         && done_o && !err_o) |-> (rd_o[WORD_W-1:8] == '0)); // R4
endmodule

bind pixconv_top pixconv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_esize (req_esize),
    .done_o    (done_o),
    .err_o     (err_o),
    .rs_o      (rs_o),
    .rd_o      (rd_o)
);

// File: tb/sim_pixconv_top.sv
module sim_pixconv_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [31:0] tbl_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [4:0]  req_ofs = '0;
    logic [5:0]  req_nbits = '0;
    logic [1:0]  req_esize = '0;
    logic [31:0] req_rt = '0;
    logic [31:0] rs_o, rd_o;
    logic        done_o, err_o;

    always #4 clk = ~clk;

    pixconv_top u0 (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .req_valid(req_valid), .req_op(req_op), .req_ofs(req_ofs), .req_nbits(req_nbits),
        .req_esize(req_esize), .req_rt(req_rt), .rs_o(rs_o), .rd_o(rd_o),
        .done_o(done_o), .err_o(err_o)
    );

    typedef struct {
        logic [31:0] rs;
        logic [31:0] rd;
        bit          err;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] tbl_m [256];
    logic [31:0] rs_m = '0;
    logic [31:0] rd_m = '0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop one expected item per completion
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_o) begin
                if (q.size() == 0) begin
                    check(0, "R2 completion with nothing issued", {31'd0, done_o}, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rs_o === e.rs, {e.tag, " rs"}, rs_o, e.rs);
                    check(rd_o === e.rd, {e.tag, " rd"}, rd_o, e.rd);
                    check(err_o === e.err, {e.tag, " err"}, {31'd0, err_o}, {31'd0, e.err});
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a[7:0]; tbl_data = d;
        tbl_m[a] = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic issue(input int op, input int ofs, input int n, input int esz,
                         input logic [31:0] rt, input string tag);
        exp_t        e;
        bit          bad;
        int          idx;
        logic [31:0] v;
        bad = (n == 0) || (ofs + n > 32) || (op < 2 && (n > 8 || esz == 3));
        if (!bad) begin
            if (op < 2) begin
                idx = int'((rt >> (32 - (ofs + n))) & ((32'd1 << n) - 1));
                v = tbl_m[idx];
                if (esz == 0) v = v & 32'h0000_00FF;
                else if (esz == 1) v = v & 32'h0000_FFFF;
                if (op == 0) rd_m = v; else rs_m = v;
            end else if (op == 2) begin
                if (ofs == 0) rs_m = rd_m << (32 - n);
                else rs_m = rs_m | (rd_m << (32 - (ofs + n)));
            end else begin
                if (ofs == 0) rs_m = rd_m;
                else rs_m = (rs_m << n) | rd_m;
            end
        end
        e.rs = rs_m; e.rd = rd_m; e.err = bad; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op[1:0]; req_ofs = ofs[4:0]; req_nbits = n[5:0];
        req_esize = esz[1:0]; req_rt = rt;
    endtask

    task automatic quiet();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        quiet();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] pixel_word(input logic [31:0] rt, input int base, input int bpp);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++) begin
            int px;
            px = int'((rt >> (32 - (base + bpp * (k + 1)))) & ((32'd1 << bpp) - 1));
            w = w | ((tbl_m[px] & 32'hFF) << (24 - 8 * k));
        end
        return w;
    endfunction

    // mode 2 = place (R6), mode 3 = accumulate (R7); whole-word result is R8
    task automatic convert(input logic [31:0] rt, input int base, input int bpp, input int mode);
        for (int k = 0; k < 4; k++) begin
            issue(0, base + bpp * k, bpp, 0, rt, "R3 field lookup");
            issue(mode, 8 * k, 8, 0, rt, (mode == 2) ? "R6 place" : "R7 accumulate");
        end
        drain();
        check(rs_o === pixel_word(rt, base, bpp), "R8 packed word", rs_o, pixel_word(rt, base, bpp));
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) tbl_m[i] = '0;
        repeat (3) @(negedge clk);
        check(rs_o === 32'd0 && rd_o === 32'd0, "R1 reset registers", rs_o | rd_o, 32'd0);
        check(done_o === 1'b0 && err_o === 1'b0, "R1 reset flags", {30'd0, done_o, err_o}, 32'd0);
        rst = 1'b0;

        // 2bpp palette with junk in the upper bytes (R4 zero-extension)
        wr(0, 32'hDEAD_BE00);
        wr(1, 32'hDEAD_BE55);
        wr(2, 32'hDEAD_BEAA);
        wr(3, 32'hDEAD_BEFF);
        wr(200, 32'h89AB_CDEF);

        // R2 latency of an isolated request
        issue(0, 0, 2, 0, 32'hC000_0000, "R2 single lookup");
        quiet();
        check(done_o === 1'b0, "R2 no result after one edge", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        check(done_o === 1'b1, "R2 result after two edges", {31'd0, done_o}, 32'd1);
        drain();

        convert(32'h1BE4_728D, 0, 2, 2);
        convert(32'h1BE4_728D, 0, 2, 3);
        convert(32'h1BE4_728D, 8, 2, 2);
        convert(32'h1BE4_728D, 22, 2, 3);

        // 1bpp palette
        wr(0, 32'hCAFE_0000);
        wr(1, 32'hCAFE_00FF);
        convert(32'hA5F0_0F3C, 0, 1, 2);
        convert(32'hA5F0_0F3C, 4, 1, 3);
        convert(32'hA5F0_0F3C, 28, 1, 2);

        // entry sizes and lookup destinations
        issue(0, 8, 8, 0, 32'h00C8_0000, "R4 one-byte entry");
        issue(0, 8, 8, 1, 32'h00C8_0000, "R4 two-byte entry");
        issue(0, 8, 8, 2, 32'h00C8_0000, "R4 four-byte entry");
        issue(1, 24, 8, 1, 32'h0000_00C8, "R5 lookup into rs");
        issue(0, 31, 1, 0, 32'h0000_0001, "R5 lookup into rd keeps rs");
        issue(3, 0, 32, 0, 32'h0, "R7 accumulate full width");
        issue(2, 16, 8, 0, 32'h0, "R6 place at offset");
        drain();

        // rejected requests
        issue(0, 0, 0, 0, 32'hFFFF_FFFF, "R9 zero width");
        issue(0, 0, 9, 0, 32'hFFFF_FFFF, "R9 lookup wider than 8");
        issue(2, 30, 8, 0, 32'hFFFF_FFFF, "R9 field past end");
        issue(1, 0, 4, 3, 32'hFFFF_FFFF, "R9 bad entry size");
        issue(3, 28, 8, 0, 32'h0, "R9 accumulate past end");
        drain();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule